// File: doc/BRIEF.md
# Interrupt State Set/Clear Register Bank

This block keeps four state bits for each interrupt source in a bank: a group bit, an enable bit, a pending latch and an active bit. A fifth per-interrupt bit holds a line-level snapshot. A single-word register port reaches all of them. Every state except group and line level has two write aliases. A 1 written to the set alias raises the bit, a 1 written to the clear alias drops it, and written 0s do nothing. Reads of either alias return the same current bits. One data bit stands for one interrupt, and byte enables narrow a write to groups of eight interrupts.

Downstream logic reads the state through parallel outputs. The pending output merges the software latch with the stored line level of every interrupt configured as level-triggered. A mode input selects the legacy behaviour, in which pending writes that target the software-generated IDs are dropped. Interrupts below the private boundary, and interrupts at or above the configured count, have no line-level storage.

Top module: `irq_state_regs`

## Requirements
- R1: An accepted request (req_ready_o is always high) gives rsp_valid_o high in the next cycle, and only then. A read returns its data in rsp_rdata_o in that cycle. A write returns 0.
- R2: The address is {view[2:0], word}. Word w covers IDs 32w to 32w+31, and data bit b maps to ID 32w+b. Byte enable bit k covers data bits 8k to 8k+7. Interrupts in lanes whose enable is 0 keep their state.
- R3: The view codes are 0 group, 1 enable-set, 2 enable-clear, 3 pending-set, 4 pending-clear, 5 active-set, 6 active-clear and 7 level. A 1 written to enable-set sets the enable bit, a 1 written to enable-clear clears it, and a written 0 changes nothing.
- R4: Reads of enable-set and enable-clear both return the current enable bits.
- R5: A group write stores the written value, 0 or 1, in every covered interrupt.
- R6: Pending-set and pending-clear have write-one semantics. When legacy_i is 1, writes to IDs 0 to 15 through either pending view are ignored. When legacy_i is 0, these IDs behave like all other IDs.
- R7: A pending read, and pending_o, give the latch OR (line level AND NOT edge_cfg_i) for each interrupt.
- R8: Active-set and active-clear have write-one semantics on the active bit, and reads of either view return the active bits. legacy_i has no effect on them.
- R9: The level view reads 0 and ignores writes for IDs below 32 and for IDs at or above IRQ_COUNT. Other IDs store the written value whatever their edge_cfg_i. A change on line_i loads the new line value into the stored level.
- R10: Reset clears the group, enable, pending, active and level bits.
- R11: group_o, enable_o, active_o and pending_o always show the current bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready, always high |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | {view, word index} |
| req_be_i | input | 4 | Byte enables for a write |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data |
| legacy_i | input | 1 | Legacy mode: software-generated IDs ignore pending writes |
| edge_cfg_i | input | NUM_IRQ | 1 marks an edge-triggered interrupt, 0 a level-triggered one |
| line_i | input | NUM_IRQ | Interrupt input lines |
| group_o | output | NUM_IRQ | Group bits |
| enable_o | output | NUM_IRQ | Enable bits |
| pending_o | output | NUM_IRQ | Merged pending view |
| active_o | output | NUM_IRQ | Active bits |

## Verification
The bench builds the block with 64 interrupts and a configured count of 48. Each view then spans two words, so the word-to-ID mapping can be seen in the upper word. The count boundary falls in the middle of word 1, so a single level read shows stored bits below the limit and zeros above it. The private boundary at 32 covers all of word 0, and the software-generated range covers its low half. A single all-ones pending write in legacy mode therefore shows both the ignored and the accepted IDs.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int NUM_LANES = WORD_W / LANE_W;

  typedef enum logic [2:0] {
    VIEW_GROUP    = 3'd0,
    VIEW_EN_SET   = 3'd1,
    VIEW_EN_CLR   = 3'd2,
    VIEW_PEND_SET = 3'd3,
    VIEW_PEND_CLR = 3'd4,
    VIEW_ACT_SET  = 3'd5,
    VIEW_ACT_CLR  = 3'd6,
    VIEW_LEVEL    = 3'd7
  } view_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_regs_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int IDX_W   = 1
) (
  input  logic                 valid_i,
  input  logic                 write_i,
  input  logic [IDX_W+2:0]     addr_i,
  input  logic [NUM_LANES-1:0] be_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output view_e                view_o,
  output logic [IDX_W-1:0]     word_o,
  output logic [NUM_IRQ-1:0]   hit_o,
  output logic [NUM_IRQ-1:0]   wbit_o
);
  assign view_o = view_e'(addr_i[IDX_W+2:IDX_W]);
  assign word_o = addr_i[IDX_W-1:0];

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    localparam int WORD = i / WORD_W;
    localparam int BIT  = i % WORD_W;
    assign hit_o[i]  = valid_i && write_i && (word_o == IDX_W'(WORD)) && be_i[BIT / LANE_W];
    assign wbit_o[i] = wdata_i[BIT];
  end
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_regs_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_SGI   = 16,
  parameter int NUM_PRIV  = 32,
  parameter int IRQ_COUNT = 48
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  view_e              view_i,
  input  logic [NUM_IRQ-1:0] hit_i,
  input  logic [NUM_IRQ-1:0] wbit_i,
  input  logic               legacy_i,
  input  logic [NUM_IRQ-1:0] line_i,
  output logic [NUM_IRQ-1:0] grp_o,
  output logic [NUM_IRQ-1:0] en_o,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] act_o,
  output logic [NUM_IRQ-1:0] lvl_o
);
  function automatic logic [NUM_IRQ-1:0] span(int lo, int hi);
    logic [NUM_IRQ-1:0] m = '0;
    for (int i = 0; i < NUM_IRQ; i++) m[i] = (i >= lo) && (i < hi);
    return m;
  endfunction

  localparam logic [NUM_IRQ-1:0] SGI_MASK = span(0, NUM_SGI);
  localparam logic [NUM_IRQ-1:0] LVL_OK   = span(NUM_PRIV, IRQ_COUNT);

  logic [NUM_IRQ-1:0] grp_q, en_q, pend_q, act_q, lvl_q, line_q;
  logic [NUM_IRQ-1:0] grp_hit, en_set, en_clr, pd_set, pd_clr, ac_set, ac_clr, lv_hit;
  logic [NUM_IRQ-1:0] pend_gate, line_chg, lvl_w;

  assign pend_gate = legacy_i ? ~SGI_MASK : '1;
  assign grp_hit = hit_i & {NUM_IRQ{view_i == VIEW_GROUP}};
  assign en_set  = hit_i & wbit_i & {NUM_IRQ{view_i == VIEW_EN_SET}};
  assign en_clr  = hit_i & wbit_i & {NUM_IRQ{view_i == VIEW_EN_CLR}};
  assign pd_set  = hit_i & wbit_i & pend_gate & {NUM_IRQ{view_i == VIEW_PEND_SET}};
  assign pd_clr  = hit_i & wbit_i & pend_gate & {NUM_IRQ{view_i == VIEW_PEND_CLR}};
  assign ac_set  = hit_i & wbit_i & {NUM_IRQ{view_i == VIEW_ACT_SET}};
  assign ac_clr  = hit_i & wbit_i & {NUM_IRQ{view_i == VIEW_ACT_CLR}};
  assign lv_hit  = hit_i & LVL_OK & {NUM_IRQ{view_i == VIEW_LEVEL}};

  // live line changes win over a bus restore in the same cycle
  assign line_chg = line_i ^ line_q;
  assign lvl_w    = (lvl_q & ~lv_hit) | (wbit_i & lv_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      lvl_q  <= '0;
      line_q <= '0;
    end else begin
      grp_q  <= (grp_q & ~grp_hit) | (wbit_i & grp_hit);
      en_q   <= (en_q | en_set) & ~en_clr;
      pend_q <= (pend_q | pd_set) & ~pd_clr;
      act_q  <= (act_q | ac_set) & ~ac_clr;
      lvl_q  <= ((lvl_w & ~line_chg) | (line_i & line_chg)) & LVL_OK;
      line_q <= line_i;
    end
  end

  assign grp_o  = grp_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign act_o  = act_q;
  assign lvl_o  = lvl_q;

  assert_en_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0 && view_i == VIEW_EN_CLR) |=> ((en_q & $past(hit_i & wbit_i)) == '0));
  assert_en_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0 && view_i == VIEW_EN_SET) |=> ((~en_q & $past(hit_i & wbit_i)) == '0));
  assert_grp_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0 && view_i == VIEW_GROUP) |=> (((grp_q ^ $past(wbit_i)) & $past(hit_i)) == '0));
  assert_sgi_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_i && (view_i == VIEW_PEND_SET || view_i == VIEW_PEND_CLR))
      |=> $stable(pend_q[NUM_SGI-1:0]));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_regs_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int IDX_W   = 1
) (
  input  view_e               view_i,
  input  logic [IDX_W-1:0]    word_i,
  input  logic [NUM_IRQ-1:0]  grp_i,
  input  logic [NUM_IRQ-1:0]  en_i,
  input  logic [NUM_IRQ-1:0]  pend_i,
  input  logic [NUM_IRQ-1:0]  act_i,
  input  logic [NUM_IRQ-1:0]  lvl_i,
  output logic [WORD_W-1:0]   rdata_o
);
  localparam int NUM_WORDS = NUM_IRQ / WORD_W;

  logic [NUM_IRQ-1:0] vec;

  always_comb begin
    unique case (view_i)
      VIEW_GROUP:                 vec = grp_i;
      VIEW_EN_SET, VIEW_EN_CLR:   vec = en_i;
      VIEW_PEND_SET, VIEW_PEND_CLR: vec = pend_i;
      VIEW_ACT_SET, VIEW_ACT_CLR: vec = act_i;
      default:                    vec = lvl_i;
    endcase
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (word_i == IDX_W'(w)) rdata_o = vec[w*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_regs_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_SGI   = 16,
  parameter int NUM_PRIV  = 32,
  parameter int IRQ_COUNT = 48,
  localparam int NUM_WORDS = NUM_IRQ / WORD_W,
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = IDX_W + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [NUM_LANES-1:0] req_be_i,
  input  logic [WORD_W-1:0]    req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [WORD_W-1:0]    rsp_rdata_o,
  input  logic                 legacy_i,
  input  logic [NUM_IRQ-1:0]   edge_cfg_i,
  input  logic [NUM_IRQ-1:0]   line_i,
  output logic [NUM_IRQ-1:0]   group_o,
  output logic [NUM_IRQ-1:0]   enable_o,
  output logic [NUM_IRQ-1:0]   pending_o,
  output logic [NUM_IRQ-1:0]   active_o
);
  view_e              view;
  logic [IDX_W-1:0]   word;
  logic [NUM_IRQ-1:0] hit, wbit, grp, en, pend, act, lvl, pend_view;
  logic [WORD_W-1:0]  rd_word;
  logic               rsp_valid_q;
  logic [WORD_W-1:0]  rsp_rdata_q;

  assign req_ready_o = 1'b1;

  irq_bus_decode #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_dec (
    .valid_i(req_valid_i), .write_i(req_write_i), .addr_i(req_addr_i),
    .be_i(req_be_i), .wdata_i(req_wdata_i),
    .view_o(view), .word_o(word), .hit_o(hit), .wbit_o(wbit)
  );

  irq_state_bank #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI), .NUM_PRIV(NUM_PRIV),
                   .IRQ_COUNT(IRQ_COUNT)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .view_i(view), .hit_i(hit), .wbit_i(wbit),
    .legacy_i(legacy_i), .line_i(line_i),
    .grp_o(grp), .en_o(en), .pend_o(pend), .act_o(act), .lvl_o(lvl)
  );

  assign pend_view = pend | (lvl & ~edge_cfg_i);

  irq_read_mux #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_mux (
    .view_i(view), .word_i(word), .grp_i(grp), .en_i(en), .pend_i(pend_view),
    .act_i(act), .lvl_i(lvl), .rdata_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_rdata_q <= (req_valid_i && !req_write_i) ? rd_word : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign group_o     = grp;
  assign enable_o    = en;
  assign pending_o   = pend_view;
  assign active_o    = act;

  assert_rsp_next_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_rsp_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_wr_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> (rsp_rdata_o == '0));
  assert_lvl_priv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && view == VIEW_LEVEL && word == '0) |=> (rsp_rdata_o == '0));
endmodule

// File: tb/sim_irq_state_regs.sv
`timescale 1ns/1ps
module sim_irq_state_regs;
  localparam int N = 64;
  localparam int CNT = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        legacy = 1'b0;
  logic [N-1:0] edge_cfg = '0, line = '0;
  logic [N-1:0] group_o, enable_o, pending_o, active_o;

  logic [N-1:0] m_grp = '0, m_en = '0, m_pend = '0, m_act = '0, m_lvl = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_state_regs #(.NUM_IRQ(N), .NUM_SGI(16), .NUM_PRIV(32), .IRQ_COUNT(CNT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_be_i(req_be),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .legacy_i(legacy), .edge_cfg_i(edge_cfg), .line_i(line),
    .group_o(group_o), .enable_o(enable_o), .pending_o(pending_o), .active_o(active_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R1", {32'd0, rsp_rdata}, 64'hdead);
      else chk(tag_q.pop_front(), {32'd0, rsp_rdata}, {32'd0, exp_q.pop_front()});
    end
  end

  function automatic logic [31:0] model_word(int view, int w);
    logic [N-1:0] v;
    case (view)
      0: v = m_grp;
      1, 2: v = m_en;
      3, 4: v = m_pend | (m_lvl & ~edge_cfg);
      5, 6: v = m_act;
      default: v = m_lvl;
    endcase
    return v[w*32 +: 32];
  endfunction

  task automatic access(bit wr, int view, int w, logic [3:0] be, logic [31:0] d, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {3'(view), 1'(w)};
    req_be = be; req_wdata = d;
    exp_q.push_back(wr ? 32'd0 : model_word(view, w));
    tag_q.push_back(tag);
    @(negedge clk);
    chk("R1", {63'd0, rsp_valid}, 64'd1);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(int view, int w, logic [3:0] be, logic [31:0] d, string tag);
    for (int i = 0; i < N; i++) begin
      if (i / 32 == w && be[(i % 32) / 8]) begin
        logic b = d[i % 32];
        case (view)
          0: m_grp[i] = b;
          1: if (b) m_en[i] = 1'b1;
          2: if (b) m_en[i] = 1'b0;
          3: if (b && !(legacy && i < 16)) m_pend[i] = 1'b1;
          4: if (b && !(legacy && i < 16)) m_pend[i] = 1'b0;
          5: if (b) m_act[i] = 1'b1;
          6: if (b) m_act[i] = 1'b0;
          default: if (i >= 32 && i < CNT) m_lvl[i] = b;
        endcase
      end
    end
    access(1'b1, view, w, be, d, tag);
  endtask

  task automatic rd(int view, int w, string tag);
    access(1'b0, view, w, 4'h0, 32'h0, tag);
  endtask

  task automatic set_line(int idx, logic v);
    @(negedge clk);
    line[idx] = v;
    if (idx >= 32 && idx < CNT) m_lvl[idx] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("R1 watchdog", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", group_o | enable_o | pending_o | active_o, 64'd0);
    chk("R1", {63'd0, rsp_valid}, 64'd0);
    rd(0, 0, "R10"); rd(7, 1, "R10");

    // R3 / R4 enable aliases
    wr(1, 0, 4'hF, 32'h0000_00A5, "R3");
    rd(1, 0, "R3");
    wr(1, 0, 4'hF, 32'h0, "R3");
    rd(1, 0, "R3");
    wr(2, 0, 4'hF, 32'h0000_0081, "R3");
    rd(2, 0, "R4");
    rd(1, 0, "R4");
    // R2 byte lanes and upper word
    wr(1, 1, 4'b0100, 32'hFFFF_FFFF, "R2");
    rd(1, 1, "R2");
    @(negedge clk);
    chk("R11", enable_o, 64'h00FF_0000_0000_0024);

    // R5 group plain write
    wr(0, 0, 4'hF, 32'hDEAD_BEEF, "R5");
    rd(0, 0, "R5");
    wr(0, 0, 4'hF, 32'h1234_5678, "R5");
    rd(0, 0, "R5");
    wr(0, 1, 4'b0001, 32'h0000_00FF, "R2");
    rd(0, 1, "R2");
    @(negedge clk);
    chk("R11", group_o, m_grp);

    // R6 pending with legacy gating
    @(negedge clk); legacy = 1'b1;
    wr(3, 0, 4'hF, 32'hFFFF_FFFF, "R6");
    rd(3, 0, "R6");
    wr(4, 0, 4'hF, 32'hFFFF_FFFF, "R6");
    rd(4, 0, "R6");
    wr(3, 0, 4'hF, 32'hFFFF_FFFF, "R6");
    @(negedge clk); legacy = 1'b0;
    wr(4, 0, 4'hF, 32'h0001_0000, "R6");
    wr(3, 0, 4'hF, 32'h0000_0005, "R6");
    rd(4, 0, "R6");
    chk("R6", {32'd0, m_pend[31:0]}, 64'hFFFE_0005);

    // R8 active aliases, unaffected by legacy
    wr(5, 1, 4'hF, 32'h8000_0001, "R8");
    rd(6, 1, "R8");
    wr(6, 1, 4'hF, 32'h0000_0001, "R8");
    rd(5, 1, "R8");
    @(negedge clk); legacy = 1'b1;
    wr(5, 0, 4'hF, 32'h0000_0004, "R8");
    rd(5, 0, "R8");
    @(negedge clk); legacy = 1'b0;
    chk("R11", active_o, 64'h8000_0000_0000_0004);

    // R9 level storage limits
    wr(7, 0, 4'hF, 32'hFFFF_FFFF, "R9");
    rd(7, 0, "R9");
    wr(7, 1, 4'hF, 32'hFFFF_FFFF, "R9");
    rd(7, 1, "R9");
    chk("R9", {32'd0, m_lvl[63:32]}, 64'h0000_FFFF);
    wr(7, 1, 4'hF, 32'h0, "R9");
    set_line(40, 1'b1);
    set_line(5, 1'b1);
    set_line(50, 1'b1);
    rd(7, 1, "R9");
    rd(7, 0, "R9");

    // R7 pending merge with level
    rd(3, 1, "R7");
    @(negedge clk);
    chk("R7", pending_o[63:32], 32'h0000_0100);
    @(negedge clk); edge_cfg[40] = 1'b1;
    rd(3, 1, "R7");
    rd(7, 1, "R9");
    @(negedge clk);
    chk("R7", pending_o, m_pend | (m_lvl & ~edge_cfg));

    // R1 idle cycle and drained scoreboard
    @(negedge clk);
    chk("R1", {63'd0, rsp_valid}, 64'd0);
    chk("R1", 64'(exp_q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule